// File: doc/BRIEF.md
# Cascadable Timer with Prescaler

This block holds two 8-bit up-counters. Each counter has its own compare byte, interrupt flag and toggle output. A free-running prescaler divides the system clock. The low timer picks one prescaler tap or a synchronized external event as its count source. The high timer picks one of three taps, or it can count compare matches of the low timer.

When the high timer is set to its cascade source and the wide-mode bit is set, the two halves become a single 16-bit counter. The low byte is least significant. The low timer's controls drive the pair, and only the low interrupt fires.

Software reaches the block through a simple synchronous register port with write enable, a 3-bit address, write data and combinational read data. Register map:

- Address 0 is the low control register:
  - bit 0: run
  - bit 1: zero strobe
  - bits 4:2: source
  - bit 5: output enable
- Address 1 is the high control register:
  - bit 0: run
  - bit 1: zero strobe
  - bits 3:2: source
  - bit 4: output enable
  - bit 5: wide mode
- Address 2 is the low compare byte and address 3 the high compare byte.
- Addresses 4 and 5 return the low and high counts. They are read-only.
- Address 6 holds the flags: bit 0 is the low flag and bit 1 the high flag.
- Unmapped addresses read zero.

Top module: `cascade_timer`

## Requirements
- R1: After reset, every register at addresses 0 to 6 reads 00h and irq_lo, irq_hi, pin_lo and pin_hi are 0.
- R2: The low source field selects the count rate. Codes 0 to 6 advance the low count once per 2, 4, 16, 64, 256, 1024 or 4096 system clocks respectively, so a run window of M times the divisor advances it by exactly M.
- R3: In 8-bit operation, a count tick that finds the low count equal to the low compare byte returns the count to 00h and sets irq_lo. The count therefore never exceeds a compare value written while it was zero.
- R4: While the run bit of a timer is 0, its count holds its value.
- R5: Writing a control register with bit 1 set forces that timer's count to 00h in the same cycle. The bit is not stored and reads back as 0. In wide mode the low zero strobe clears both halves.
- R6: A flag stays set until one of two things happens: a write to address 6 with a 1 in the flag's bit, or a one-cycle pulse on its acknowledge input. Writing 0 leaves it set. A match in the same cycle as a clear keeps the flag set.
- R7: With output enable set, the timer's output flip-flop toggles on every compare match and drives its pin. With output enable clear, the pin is 0 and the flip-flop holds.
- R8: Low source code 7 counts rising edges of ext_evt after a two-stage synchronizer. Each rising edge advances the count by one, and a level held high adds nothing more.
- R9: In 8-bit operation, high source code 3 advances the high count once per low-timer compare match.
- R10: High source codes 0, 1 and 2 advance the high count once per 2, 16 and 256 system clocks.
- R11: Wide mode is active when the wide bit is 1 and the high source field is 3. In wide mode the pair counts as {high, low}, gated by the low run bit and low source, and carries from low byte FFh into the high byte. A tick that finds it equal to {high compare, low compare} returns it to 0000h. The low compare byte must be 01h to FFh in this mode.
- R12: In wide mode a 16-bit match sets irq_lo and toggles the low output flip-flop, and irq_hi never rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_evt | input | 1 | External event input, counted on rising edges |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_addr |
| ack_lo | input | 1 | Clears the low flag |
| ack_hi | input | 1 | Clears the high flag |
| irq_lo | output | 1 | Low timer interrupt flag |
| irq_hi | output | 1 | High timer interrupt flag |
| pin_lo | output | 1 | Low timer toggle output |
| pin_hi | output | 1 | High timer toggle output |

## Verification
The properties take three things for granted about the inputs:
- the count registers change only through ticks and the zero strobe, never through writes;
- acknowledge pulses come synchronously with the clock;
- in wide mode the low compare byte is never 00h.

The directed stimulus follows these rules. It drives every input just after a falling edge and never writes a zero low compare while wide mode is set. It also stops a timer before reading a multi-byte count, so both bytes come from one settled value.

// File: rtl/cascade_timer.sv
module cascade_timer #(
  parameter int DW = 8,
  parameter int PW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ext_evt,
  input  logic          reg_we,
  input  logic [2:0]    reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          ack_lo,
  input  logic          ack_hi,
  output logic          irq_lo,
  output logic          irq_hi,
  output logic          pin_lo,
  output logic          pin_hi
);

  logic          run_lo, oe_lo, run_hi, oe_hi, wide;
  logic [2:0]    src_lo;
  logic [1:0]    src_hi;
  logic [DW-1:0] cmp_lo, cmp_hi, cnt_lo, cnt_hi;
  logic          flag_lo, flag_hi, ff_lo, ff_hi;
  logic [PW-1:0] pre;
  logic [2:0]    ev_q;

  logic wr_cl, wr_ch, wr_fl, zero_lo, zero_hi, mode16, ev_rise;
  logic src_tick_lo, src_tick_hi, tick_lo, tick_hi;
  logic hit16, hit_lo8, match_lo, match_hi;

  assign wr_cl   = reg_we && reg_addr == 3'd0;
  assign wr_ch   = reg_we && reg_addr == 3'd1;
  assign wr_fl   = reg_we && reg_addr == 3'd6;
  assign zero_lo = wr_cl && reg_wdata[1];
  assign zero_hi = wr_ch && reg_wdata[1];
  assign mode16  = wide && src_hi == 2'b11;
  assign ev_rise = ev_q[1] && !ev_q[2];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pre  <= '0;
      ev_q <= '0;
    end else begin
      pre  <= pre + 1'b1;
      ev_q <= {ev_q[1:0], ext_evt};
    end

  always_comb begin
    case (src_lo)
      3'd0:    src_tick_lo = pre[0];
      3'd1:    src_tick_lo = &pre[1:0];
      3'd2:    src_tick_lo = &pre[3:0];
      3'd3:    src_tick_lo = &pre[5:0];
      3'd4:    src_tick_lo = &pre[7:0];
      3'd5:    src_tick_lo = &pre[9:0];
      3'd6:    src_tick_lo = &pre[11:0];
      default: src_tick_lo = ev_rise;
    endcase
  end

  assign tick_lo  = run_lo && src_tick_lo;
  assign hit16    = mode16 && tick_lo && {cnt_hi, cnt_lo} == {cmp_hi, cmp_lo};
  assign hit_lo8  = !mode16 && tick_lo && cnt_lo == cmp_lo;
  assign match_lo = hit16 || hit_lo8;

  always_comb begin
    case (src_hi)
      2'd0:    src_tick_hi = pre[0];
      2'd1:    src_tick_hi = &pre[3:0];
      2'd2:    src_tick_hi = &pre[7:0];
      default: src_tick_hi = hit_lo8;
    endcase
  end

  assign tick_hi  = !mode16 && run_hi && src_tick_hi;
  assign match_hi = tick_hi && cnt_hi == cmp_hi;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      run_lo <= 1'b0; oe_lo <= 1'b0; src_lo <= '0;
      run_hi <= 1'b0; oe_hi <= 1'b0; src_hi <= '0; wide <= 1'b0;
      cmp_lo <= '0; cmp_hi <= '0;
    end else if (reg_we) begin
      case (reg_addr)
        3'd0: begin
          run_lo <= reg_wdata[0];
          src_lo <= reg_wdata[4:2];
          oe_lo  <= reg_wdata[5];
        end
        3'd1: begin
          run_hi <= reg_wdata[0];
          src_hi <= reg_wdata[3:2];
          oe_hi  <= reg_wdata[4];
          wide   <= reg_wdata[5];
        end
        3'd2: cmp_lo <= reg_wdata;
        3'd3: cmp_hi <= reg_wdata;
        default: ;
      endcase
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)            cnt_lo <= '0;
    else if (zero_lo)      cnt_lo <= '0;
    else if (tick_lo)      cnt_lo <= match_lo ? '0 : cnt_lo + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                          cnt_hi <= '0;
    else if (zero_hi || (zero_lo && mode16)) cnt_hi <= '0;
    else if (mode16 && tick_lo) begin
      if (hit16)              cnt_hi <= '0;
      else if (cnt_lo == '1)  cnt_hi <= cnt_hi + 1'b1;
    end else if (tick_hi)     cnt_hi <= match_hi ? '0 : cnt_hi + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      flag_lo <= 1'b0; flag_hi <= 1'b0;
      ff_lo   <= 1'b0; ff_hi   <= 1'b0;
    end else begin
      flag_lo <= match_lo || (flag_lo && !(ack_lo || (wr_fl && reg_wdata[0])));
      flag_hi <= match_hi || (flag_hi && !(ack_hi || (wr_fl && reg_wdata[1])));
      if (match_lo && oe_lo) ff_lo <= !ff_lo;
      if (match_hi && oe_hi) ff_hi <= !ff_hi;
    end

  always_comb begin
    case (reg_addr)
      3'd0:    reg_rdata = DW'({oe_lo, src_lo, 1'b0, run_lo});
      3'd1:    reg_rdata = DW'({wide, oe_hi, src_hi, 1'b0, run_hi});
      3'd2:    reg_rdata = cmp_lo;
      3'd3:    reg_rdata = cmp_hi;
      3'd4:    reg_rdata = cnt_lo;
      3'd5:    reg_rdata = cnt_hi;
      3'd6:    reg_rdata = DW'({flag_hi, flag_lo});
      default: reg_rdata = '0;
    endcase
  end

  assign irq_lo = flag_lo;
  assign irq_hi = flag_hi;
  assign pin_lo = oe_lo && ff_lo;
  assign pin_hi = oe_hi && ff_hi;

endmodule

// File: rtl/cascade_timer_chk.sv
module cascade_timer_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          irq_lo,
  input logic          irq_hi,
  input logic          ack_lo,
  input logic [DW-1:0] cnt_lo,
  input logic          run_lo,
  input logic          zero_lo,
  input logic          oe_lo,
  input logic          ff_lo,
  input logic          mode16
);

  assert_match_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_lo) |-> cnt_lo == '0);

  assert_hold_stopped_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_lo && !zero_lo) |=> $stable(cnt_lo));

  assert_ack_drops_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ack_lo |=> (!irq_lo || cnt_lo == '0));

  assert_pin_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_lo |=> $stable(ff_lo));

  assert_no_hi_irq_wide_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (mode16 && $past(mode16)) |-> !$rose(irq_hi));

endmodule

bind cascade_timer cascade_timer_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_lo(irq_lo), .irq_hi(irq_hi), .ack_lo(ack_lo),
  .cnt_lo(cnt_lo), .run_lo(run_lo), .zero_lo(zero_lo), .oe_lo(oe_lo),
  .ff_lo(ff_lo), .mode16(mode16)
);

// File: tb/cascade_timer_test.sv
`timescale 1ns/100ps
module cascade_timer_test;
  logic       clk = 1'b0, rst_n = 1'b0, ext_evt = 1'b0;
  logic       reg_we = 1'b0, ack_lo = 1'b0, ack_hi = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic       irq_lo, irq_hi, pin_lo, pin_hi;
  int checks = 0, failures = 0;
  bit done = 0;

  cascade_timer uut (.*);

  always #2.5 clk = !clk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic rd_chk(input logic [2:0] a, input logic [7:0] exp, input string tag);
    logic [7:0] d;
    rd(a, d);
    check(d == exp, tag, d, exp);
  endtask

  task automatic run_lo_for(input logic [7:0] ctl, input int n);
    wr(3'd0, ctl | 8'h01);
    repeat (n - 1) @(negedge clk);
    wr(3'd0, ctl & 8'hFE);
  endtask

  task automatic t_reset;
    for (int a = 0; a < 7; a++) rd_chk(3'(a), 8'h00, "R1 reset register");
    check({irq_lo, irq_hi, pin_lo, pin_hi} == 4'b0, "R1 reset outputs",
          {irq_lo, irq_hi, pin_lo, pin_hi}, 0);
  endtask

  task automatic t_prescale;
    int div [7] = '{2, 4, 16, 64, 256, 1024, 4096};
    wr(3'd2, 8'hFF);
    for (int s = 0; s < 7; s++) begin
      wr(3'd0, 8'(s << 2) | 8'h02);
      run_lo_for(8'(s << 2), 3 * div[s]);
      rd_chk(3'd4, 8'd3, "R2 prescaler tap rate");
    end
  endtask

  task automatic t_hold;
    repeat (50) @(negedge clk);
    rd_chk(3'd4, 8'd3, "R4 stopped count holds");
  endtask

  task automatic t_zero;
    wr(3'd0, 8'h0A);
    rd_chk(3'd4, 8'd0, "R5 zero strobe clears count");
    rd_chk(3'd0, 8'h08, "R5 zero bit not stored");
  endtask

  task automatic t_match;
    logic [7:0] d, mx;
    bit seen = 0;
    mx = 0;
    wr(3'd2, 8'd5);
    wr(3'd0, 8'h02);
    wr(3'd0, 8'h01);
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      rd(3'd4, d);
      if (d > mx) mx = d;
      if (irq_lo) seen = 1;
    end
    wr(3'd0, 8'h00);
    check(mx == 8'd5, "R3 count peaks at compare", mx, 5);
    check(seen, "R3 match raises irq_lo", seen, 1);
  endtask

  task automatic t_flags;
    wr(3'd6, 8'h00);
    check(irq_lo == 1'b1, "R6 writing 0 keeps flag", irq_lo, 1);
    wr(3'd6, 8'h01);
    check(irq_lo == 1'b0, "R6 write-one clears flag", irq_lo, 0);
    run_lo_for(8'h00, 12);
    rd_chk(3'd6, 8'h01, "R6 flag readback after match");
    ack_lo = 1'b1;
    @(negedge clk);
    ack_lo = 1'b0;
    check(irq_lo == 1'b0, "R6 acknowledge clears flag", irq_lo, 0);
  endtask

  task automatic t_toggle;
    logic prev;
    int tog = 0, moves = 0;
    wr(3'd0, 8'h22);
    wr(3'd0, 8'h21);
    repeat (20) @(negedge clk);
    prev = pin_lo;
    for (int i = 0; i < 96; i++) begin
      @(negedge clk);
      if (pin_lo != prev) tog++;
      prev = pin_lo;
    end
    check(tog == 8, "R7 pin toggles per match", tog, 8);
    wr(3'd0, 8'h01);
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      if (pin_lo) moves++;
    end
    wr(3'd0, 8'h00);
    check(moves == 0, "R7 pin low with output disabled", moves, 0);
  endtask

  task automatic t_ext;
    wr(3'd2, 8'hFF);
    wr(3'd0, 8'h1E);
    wr(3'd0, 8'h1D);
    for (int i = 0; i < 5; i++) begin
      ext_evt = 1'b1; repeat (3) @(negedge clk);
      ext_evt = 1'b0; repeat (3) @(negedge clk);
    end
    repeat (4) @(negedge clk);
    rd_chk(3'd4, 8'd5, "R8 one count per event edge");
    ext_evt = 1'b1;
    repeat (20) @(negedge clk);
    rd_chk(3'd4, 8'd6, "R8 held level adds one edge only");
    ext_evt = 1'b0;
    wr(3'd0, 8'h1C);
  endtask

  task automatic t_cascade;
    wr(3'd2, 8'd3);
    wr(3'd3, 8'hFF);
    wr(3'd0, 8'h02);
    wr(3'd1, 8'h0E);
    wr(3'd1, 8'h0D);
    run_lo_for(8'h00, 80);
    rd_chk(3'd4, 8'd0, "R9 low count after ten periods");
    rd_chk(3'd5, 8'd10, "R9 high counts low matches");
  endtask

  task automatic t_hi_pre;
    wr(3'd1, 8'h02);
    wr(3'd1, 8'h01);
    repeat (39) @(negedge clk);
    wr(3'd1, 8'h00);
    rd_chk(3'd5, 8'd20, "R10 high divide by 2");
    wr(3'd1, 8'h06);
    wr(3'd1, 8'h05);
    repeat (47) @(negedge clk);
    wr(3'd1, 8'h04);
    rd_chk(3'd5, 8'd3, "R10 high divide by 16");
  endtask

  task automatic t_wide;
    wr(3'd2, 8'h05);
    wr(3'd3, 8'h01);
    wr(3'd1, 8'h2C);
    wr(3'd6, 8'h03);
    wr(3'd0, 8'h02);
    rd_chk(3'd5, 8'h00, "R5 wide zero clears high byte");
    run_lo_for(8'h00, 520);
    rd_chk(3'd4, 8'h04, "R11 wide low byte");
    rd_chk(3'd5, 8'h01, "R11 wide carry into high byte");
    check(irq_lo == 1'b0, "R11 no match before compare", irq_lo, 0);
    run_lo_for(8'h00, 80);
    rd_chk(3'd4, 8'h26, "R11 wide wrap low byte");
    rd_chk(3'd5, 8'h00, "R11 wide wrap high byte");
    check(irq_lo == 1'b1, "R12 wide match sets low flag", irq_lo, 1);
    check(irq_hi == 1'b0, "R12 wide match leaves high flag", irq_hi, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_prescale();
    t_hold();
    t_zero();
    t_match();
    t_flags();
    t_toggle();
    t_ext();
    t_cascade();
    t_hi_pre();
    t_wide();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule